// File: doc/BRIEF.md
# Configurable Floating-Point Minimum/Maximum Unit

This unit takes two binary64 operands and a four-bit mode field and returns one of the two operands, or a quieted copy of one, as the smaller or the larger value. The mode field selects minimum or maximum, signed or magnitude ordering, and one of four conventions for inputs that are NaN: the 2008 "number wins" rule, the 2019 "NaN propagates" rule, the 2019 "number wins" rule without signaling priority, and a C-library style rule that returns the second operand.

The selection logic is combinational and feeds one output register. A signaling NaN on either input raises an invalid-operation flag. When the caller has enabled that exception, the destination write is suppressed. The unit is intended as a single-cycle slot in a floating-point execution pipe. The issue stage drives a valid strobe with the operands. The writeback stage uses the write-enable and the flag one clock later.

Top module: `fmm_unit`

## Requirements
- R1: `out_valid` equals `in_valid` from one clock earlier. Reset clears `out_valid`, `wr_en` and `snan_flag`, and `wr_en` and `snan_flag` are never high while `out_valid` is low.
- R2: An operand is a NaN when its 63 low bits, read as unsigned, exceed 0x7FF0_0000_0000_0000. It is signaling when bit 51 is 0. The quieted copy is the operand with bit 51 forced to 1.
- R3: With `mode[1:0]`=00 and at least one NaN input, the result is chosen in this order: a signaling A gives quieted A; then a signaling B gives quieted B; then two NaNs give quieted A; otherwise the non-NaN operand is returned unchanged.
- R4: With `mode[1:0]`=01 and at least one NaN input, a NaN A gives quieted A, and otherwise the result is quieted B.
- R5: With `mode[1:0]`=10 and at least one NaN input, two NaNs give quieted A and a single NaN gives the other operand unchanged. Signaling NaNs get no priority.
- R6: With `mode[1:0]`=11 and at least one NaN input, B is returned bit for bit.
- R7: With `mode[1:0]`=11 and no NaN, a zero of either sign counts as +0, so a pair of zeros of any signs returns B.
- R8: With `mode[3]`=0 (minimum) and no NaN, ordering follows the real values, with -0 below +0 in the conventions other than 11. A is returned when it is strictly smaller; otherwise B is returned.
- R9: With `mode[3]`=1 (maximum), A is returned only when it is strictly larger, so bit-identical or tied inputs return B.
- R10: With `mode[2]`=1 and magnitudes that differ, the operands are ordered by absolute value. Equal magnitudes, such as +x and -x, fall back to signed ordering.
- R11: `snan_flag` is high with a result exactly when either input of that operation was a signaling NaN.
- R12: `wr_en` is high with a result when `inv_en` was 0 or no signaling NaN was present, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| op_a | input | 64 | Operand A, binary64 |
| op_b | input | 64 | Operand B, binary64 |
| mode | input | 4 | [3] max, [2] magnitude, [1:0] NaN convention |
| inv_en | input | 1 | Invalid-operation exception enable |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| result | output | 64 | Selected operand or quieted NaN |
| wr_en | output | 1 | Destination write permitted |
| snan_flag | output | 1 | A signaling NaN was seen |

## Verification
The bench applies every one of the 16 mode encodings to every ordered pair from a set of fourteen operands: ±0, ±1, ±2, ±Inf, the smallest positive and negative denormals, quiet NaNs of both signs, and signaling NaNs of both signs. Each vector runs with the exception enable off and on. The ±0 and ±1 pairs distinguish the signed fallback from magnitude ordering and from the C-style zero folding. Identical operands expose the tie rule that returns B under both minimum and maximum. The NaN pairs distinguish the four conventions through which operand is quieted and returned, and they show whether signaling inputs take priority.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

    // NaN-handling convention, low two bits of the mode field
    typedef enum logic [1:0] {
        NAN_NUM08  = 2'b00,
        NAN_MM19   = 2'b01,
        NAN_NUM19  = 2'b10,
        NAN_CSTYLE = 2'b11
    } nan_conv_e;

    // Mode field as seen on the port: [3] max, [2] magnitude, [1:0] convention
    typedef struct packed {
        logic      do_max;
        logic      do_mag;
        nan_conv_e conv;
    } mode_t;

endpackage

// File: rtl/fmm_classify.sv
module fmm_classify #(
    parameter int W  = 64,
    parameter int EW = 11
) (
    input  logic [W-1:0] x,
    output logic         is_nan,
    output logic         is_snan,
    output logic         is_zero,
    output logic [W-1:0] mag,
    output logic [W-1:0] quiet
);
    localparam int FW = W - 1 - EW;
    localparam int QB = FW - 1;
    localparam logic [W-1:0] INF_PAT = {1'b0, {EW{1'b1}}, {FW{1'b0}}};

    assign mag     = {1'b0, x[W-2:0]};
    assign is_nan  = mag > INF_PAT;
    assign is_snan = is_nan & ~x[QB];
    assign is_zero = (mag == '0);

    always_comb begin
        quiet     = x;
        quiet[QB] = 1'b1;
    end
endmodule

// File: rtl/fmm_order.sv
module fmm_order #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] mag_a,
    input  logic [W-1:0] mag_b,
    input  logic         zero_a,
    input  logic         zero_b,
    input  logic         do_max,
    input  logic         do_mag,
    input  logic         zero_fold,
    output logic         pick_a
);
    logic [W-1:0] lhs, rhs, l_sw, r_sw;

    always_comb begin
        lhs = a;
        rhs = b;
        if (do_mag && (mag_a != mag_b)) begin
            lhs = mag_a;
            rhs = mag_b;
        end
        if (zero_fold) begin
            if (zero_a) lhs = '0;
            if (zero_b) rhs = '0;
        end
        // maximum is the same less-than with the sides exchanged
        l_sw = do_max ? rhs : lhs;
        r_sw = do_max ? lhs : rhs;
    end

    // sign-magnitude less-than of l_sw against r_sw
    always_comb begin
        if (l_sw[W-1]) begin
            if (!r_sw[W-1]) pick_a = 1'b1;
            else            pick_a = l_sw > r_sw;
        end else begin
            if (r_sw[W-1])  pick_a = 1'b0;
            else            pick_a = l_sw < r_sw;
        end
    end
endmodule

// File: rtl/fmm_nan_sel.sv
module fmm_nan_sel
    import fmm_pkg::*;
#(
    parameter int W = 64
) (
    input  nan_conv_e    conv,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] qa,
    input  logic [W-1:0] qb,
    input  logic         a_nan,
    input  logic         a_snan,
    input  logic         b_nan,
    input  logic         b_snan,
    output logic [W-1:0] res
);
    always_comb begin
        res = b;
        unique case (conv)
            NAN_NUM08: begin
                if (a_snan)              res = qa;
                else if (b_snan)         res = qb;
                else if (a_nan && b_nan) res = qa;
                else if (a_nan)          res = b;
                else                     res = a;
            end
            NAN_MM19: begin
                res = a_nan ? qa : qb;
            end
            NAN_NUM19: begin
                if (a_nan && b_nan)      res = qa;
                else if (a_nan)          res = b;
                else                     res = a;
            end
            NAN_CSTYLE: begin
                res = b;
            end
        endcase
    end
endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
    import fmm_pkg::*;
#(
    parameter int W  = 64,
    parameter int EW = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   mode,
    input  logic         inv_en,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         wr_en,
    output logic         snan_flag
);
    localparam int NOP = 2;

    mode_t m;
    assign m = mode_t'(mode);

    logic [NOP-1:0][W-1:0] opnd, mag, qv;
    logic [NOP-1:0]        nan, snan, zero;

    assign opnd[0] = op_a;
    assign opnd[1] = op_b;

    for (genvar g = 0; g < NOP; g++) begin : g_cls
        fmm_classify #(.W(W), .EW(EW)) u_cls (
            .x       (opnd[g]),
            .is_nan  (nan[g]),
            .is_snan (snan[g]),
            .is_zero (zero[g]),
            .mag     (mag[g]),
            .quiet   (qv[g])
        );
    end

    logic         pick_a;
    logic [W-1:0] nan_res, sel_res;
    logic         any_nan, any_snan;

    assign any_nan  = |nan;
    assign any_snan = |snan;

    fmm_order #(.W(W)) u_ord (
        .a         (op_a),
        .b         (op_b),
        .mag_a     (mag[0]),
        .mag_b     (mag[1]),
        .zero_a    (zero[0]),
        .zero_b    (zero[1]),
        .do_max    (m.do_max),
        .do_mag    (m.do_mag),
        .zero_fold (m.conv == NAN_CSTYLE),
        .pick_a    (pick_a)
    );

    fmm_nan_sel #(.W(W)) u_nan (
        .conv   (m.conv),
        .a      (op_a),
        .b      (op_b),
        .qa     (qv[0]),
        .qb     (qv[1]),
        .a_nan  (nan[0]),
        .a_snan (snan[0]),
        .b_nan  (nan[1]),
        .b_snan (snan[1]),
        .res    (nan_res)
    );

    assign sel_res = any_nan ? nan_res : (pick_a ? op_a : op_b);

    // single output register stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            wr_en     <= 1'b0;
            snan_flag <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            wr_en     <= in_valid & (~inv_en | ~any_snan);
            snan_flag <= in_valid & any_snan;
            if (in_valid) result <= sel_res;
        end
    end
endmodule

// File: rtl/fmm_unit_chk.sv
module fmm_unit_chk #(
    parameter int W  = 64,
    parameter int EW = 11
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic         inv_en,
    input logic         out_valid,
    input logic [W-1:0] result,
    input logic         wr_en,
    input logic         snan_flag
);
    localparam int QB = W - 2 - EW;
    localparam logic [W-1:0] QMASK = {{(W-1-QB){1'b0}}, 1'b1, {QB{1'b0}}};

    // R1
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R1
    wr_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> out_valid);

    // R11
    flag_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snan_flag |-> out_valid);

    // R12
    wr_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && snan_flag && $past(inv_en)) |-> !wr_en);

    // R12
    wr_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !snan_flag) |-> wr_en);

    // R2
    result_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (result == $past(op_a) || result == $past(op_b) ||
                       result == ($past(op_a) | QMASK) ||
                       result == ($past(op_b) | QMASK)));
endmodule

bind fmm_unit fmm_unit_chk #(.W(W), .EW(EW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .inv_en    (inv_en),
    .out_valid (out_valid),
    .result    (result),
    .wr_en     (wr_en),
    .snan_flag (snan_flag)
);

// File: tb/tb_fmm_unit.sv
module tb_fmm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [3:0]  mode = '0;
    logic        inv_en = 1'b0;
    logic        out_valid, wr_en, snan_flag;
    logic [63:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fmm_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .mode(mode), .inv_en(inv_en), .out_valid(out_valid), .result(result),
        .wr_en(wr_en), .snan_flag(snan_flag)
    );

    localparam int NV = 14;
    logic [63:0] vals [NV];

    function automatic bit f_nan(input logic [63:0] x);
        return (x[62:52] == 11'h7FF) && (x[51:0] != '0);
    endfunction

    function automatic bit f_snan(input logic [63:0] x);
        return f_nan(x) && !x[51];
    endfunction

    function automatic logic [63:0] f_quiet(input logic [63:0] x);
        return x | (64'd1 << 51);
    endfunction

    // monotonic integer key: smaller real value gives smaller key
    function automatic logic [63:0] f_key(input logic [63:0] x);
        return x[63] ? ~x : (x ^ (64'd1 << 63));
    endfunction

    function automatic logic [63:0] f_ref(input logic [63:0] a, input logic [63:0] b,
                                          input logic [3:0] md);
        logic [62:0] ma, mb;
        bit lt;
        ma = a[62:0];
        mb = b[62:0];
        if (f_nan(a) || f_nan(b)) begin
            case (md[1:0])
                2'b00: begin // R3
                    if (f_snan(a)) return f_quiet(a);
                    if (f_snan(b)) return f_quiet(b);
                    if (f_nan(a) && f_nan(b)) return f_quiet(a);
                    return f_nan(a) ? b : a;
                end
                2'b01: return f_nan(a) ? f_quiet(a) : f_quiet(b); // R4
                2'b10: begin // R5
                    if (f_nan(a) && f_nan(b)) return f_quiet(a);
                    return f_nan(a) ? b : a;
                end
                default: return b; // R6
            endcase
        end
        if (md[1:0] == 2'b11 && ma == 0 && mb == 0) return b; // R7
        if (md[2] && ma != mb) begin // R10
            lt = md[3] ? (mb < ma) : (ma < mb);
        end else begin // R8, R9
            lt = md[3] ? (f_key(b) < f_key(a)) : (f_key(a) < f_key(b));
        end
        return lt ? a : b;
    endfunction

    function automatic string f_tag(input logic [63:0] a, input logic [63:0] b,
                                    input logic [3:0] md);
        if (f_nan(a) || f_nan(b)) begin
            case (md[1:0])
                2'b00:   return "R3";
                2'b01:   return "R4";
                2'b10:   return "R5";
                default: return "R6";
            endcase
        end
        if (md[1:0] == 2'b11 && a[62:0] == 0 && b[62:0] == 0) return "R7";
        if (md[2]) return "R10";
        return md[3] ? "R9" : "R8";
    endfunction

    task automatic run_vec(input logic [63:0] a, input logic [63:0] b,
                           input logic [3:0] md, input logic ie);
        logic [63:0] er;
        bit ef, ew;
        @(negedge clk);
        op_a = a; op_b = b; mode = md; inv_en = ie; in_valid = 1'b1;
        er = f_ref(a, b, md);
        ef = f_snan(a) || f_snan(b);
        ew = !ie || !ef;
        @(negedge clk);
        checks++;
        if (!out_valid) begin
            fails++;
            $display("FAIL R1 out_valid=%0b expected 1", out_valid);
        end else if (snan_flag !== ef) begin
            fails++;
            $display("FAIL R11 a=%h b=%h flag=%0b expected %0b", a, b, snan_flag, ef);
        end else if (wr_en !== ew) begin
            fails++;
            $display("FAIL R12 a=%h b=%h ie=%0b wr_en=%0b expected %0b", a, b, ie, wr_en, ew);
        end else if (result !== er) begin
            fails++;
            if (er != a && er != b)
                $display("FAIL R2/%s a=%h b=%h mode=%h result=%h expected %h",
                         f_tag(a, b, md), a, b, md, result, er);
            else
                $display("FAIL %s a=%h b=%h mode=%h result=%h expected %h",
                         f_tag(a, b, md), a, b, md, result, er);
        end
    endtask

    initial begin
        vals[0]  = 64'h0000_0000_0000_0000; // +0
        vals[1]  = 64'h8000_0000_0000_0000; // -0
        vals[2]  = 64'h3FF0_0000_0000_0000; // +1
        vals[3]  = 64'hBFF0_0000_0000_0000; // -1
        vals[4]  = 64'h4000_0000_0000_0000; // +2
        vals[5]  = 64'hC000_0000_0000_0000; // -2
        vals[6]  = 64'h7FF0_0000_0000_0000; // +Inf
        vals[7]  = 64'hFFF0_0000_0000_0000; // -Inf
        vals[8]  = 64'h0000_0000_0000_0001; // +denormal
        vals[9]  = 64'h8000_0000_0000_0001; // -denormal
        vals[10] = 64'h7FF8_0000_0000_0005; // +qNaN
        vals[11] = 64'hFFF8_0000_0000_0000; // -qNaN
        vals[12] = 64'h7FF0_0000_0000_0001; // +sNaN
        vals[13] = 64'hFFF4_0000_0000_0003; // -sNaN

        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || wr_en !== 1'b0 || snan_flag !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs v=%0b w=%0b f=%0b expected 0 0 0",
                     out_valid, wr_en, snan_flag);
        end
        rst_n = 1'b1;

        for (int md = 0; md < 16; md++)
            for (int i = 0; i < NV; i++)
                for (int j = 0; j < NV; j++)
                    for (int ie = 0; ie < 2; ie++)
                        run_vec(vals[i], vals[j], 4'(md), 1'(ie));

        // R1: valid drops one clock after the strobe drops
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || wr_en !== 1'b0 || snan_flag !== 1'b0) begin
            fails++;
            $display("FAIL R1 idle outputs v=%0b w=%0b f=%0b expected 0 0 0",
                     out_valid, wr_en, snan_flag);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired, run incomplete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule